// File: doc/BRIEF.md
# Keypad Matrix Scan Controller

This block scans a keypad wired as a matrix of row lines and column lines. It drives the rows low one at a time and reads the column lines back. It keeps one 16-bit result word per row. Software uses a small word-addressed register port to pick a scan mode, the settle time for each row, the pause between scans, and how many rows and columns to scan. Column inputs are active low, so a pressed key on the driven row reads as 0.

There are four modes. Idle drives nothing. Any-key detect drives every row at once and only raises a flag while some key is held. Single scan reads the enabled rows once and then returns the mode field to idle. Continuous scan repeats, with a programmable pause between scans. A three-bit status word records scan completion, changed data and any-key detection. Each bit is cleared by writing 1 to it, and a mask gates the status bits onto a single interrupt line.

Top module: `kpd_scan_top`

## Requirements
- R1: After reset, every register reads 0 except the row data, every row word reads 0xFFFF, all row outputs are high, and `irq` is 0.
- R2: Registers sit at these word offsets, and only when the two low address bits are 0: 0x00 control (mode in bits 1:0, row settle cycles in 15:2, gap cycles in 31:16), 0x04 size (row count in 7:0, column count in 15:8), 0x08 status, 0x0C mask (bits 2:0), and 0x10 to 0x2F row data (row 2k in bits 15:0 and row 2k+1 in bits 31:16 of word 0x10+4k). Any other address reads 0, and a write to it has no effect.
- R3: Mode values are 0 idle, 1 any-key, 2 single scan and 3 continuous scan. In modes 2 and 3 at most one row output is low at a time. In mode 1 all row outputs are low. In mode 0 all row outputs are high.
- R4: In a single scan, each enabled row is driven for settle+1 cycles and its columns are sampled in the last of those cycles. After the last enabled row is sampled, the mode field reads 0 and status bit 0 (scan done) is set.
- R5: Only rows below the row count are scanned and written. Other rows keep their earlier contents. A row count above 16 acts as 16, and a count of 0 completes the scan without writing any row.
- R6: In a written row, column bits at or above the column count are stored as 1.
- R7: Status bit 1 is set when a scan completes if any written row differs from its value before that scan, and it stays 0 otherwise.
- R8: In mode 1 no row data is written. Status bit 2 is set while any column input is low, and writing 1 to it does not clear it until the key is released.
- R9: In mode 3 the mode field stays 3, and row 0 goes low again every rows*(settle+1)+gap+1 cycles.
- R10: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R11: Writing a mode of 0 during a scan releases all rows on the next cycle, and no scan-done status follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| row_drive_n | output | ROWS | Row select lines, active low |
| col_in_n | input | COLS | Column sense lines, low when a key on the driven row is pressed |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong row index or a wrong settle count shows up on `row_drive_n` within one settle period. It appears as two rows low at once, a row held too long, or a period in continuous mode that does not match the formula. A corrupted sample or a write to the wrong row shows up at the next data read after the scan completes, and each word in the data window is compared with a model of the matrix. A lost or stuck event flag shows up on the status word and on `irq` in the cycle right after the scan completes. The any-key flag is probed across a write-one-to-clear, both while a key is held and after it is released.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ANYKEY = 2'd1,
    MODE_ONCE   = 2'd2,
    MODE_LOOP   = 2'd3
  } kpd_mode_e;

  // limit a programmed count to the number of rows that exist
  function automatic logic [7:0] clamp_count(input logic [7:0] n, input logic [7:0] lim);
    return (n > lim) ? lim : n;
  endfunction

  // columns at or beyond the programmed width read as released
  function automatic logic [HALF_W-1:0] fill_cols(input logic [HALF_W-1:0] raw,
                                                  input logic [7:0] ncols);
    logic [HALF_W-1:0] r;
    r = raw;
    for (int c = 0; c < int'(HALF_W); c++) begin
      if (c >= int'(ncols)) r[c] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/kpd_regs.sv
module kpd_regs
  import kpd_pkg::*;
#(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [31:0]       wdata,
  input  logic              evt_done,
  input  logic              evt_chg,
  input  logic              evt_key,
  input  logic              clr_mode,
  output logic [31:0]       ctrl_q,
  output logic [15:0]       size_q,
  output logic [2:0]        status_q,
  output logic [2:0]        mask_q,
  output logic              irq
);

  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_SIZE = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_MASK = WORD_W'(3);

  logic [2:0] stat_set;
  logic [2:0] stat_clr;

  assign stat_set = {evt_key, evt_chg, evt_done};
  assign stat_clr = (wr_en && word == W_STAT) ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      size_q   <= '0;
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      if (wr_en && word == W_CTRL) ctrl_q <= wdata;
      else if (clr_mode)          ctrl_q[1:0] <= 2'b00;
      if (wr_en && word == W_SIZE) size_q <= wdata[15:0];
      if (wr_en && word == W_MASK) mask_q <= wdata[2:0];
      // a new event wins over a clear in the same cycle
      status_q <= (status_q & ~stat_clr) | stat_set;
    end
  end

  assign irq = |(status_q & mask_q);

endmodule

// File: rtl/kpd_rowstore.sv
module kpd_rowstore
  import kpd_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  cmp_row,
  output logic [HALF_W-1:0] cmp_data,
  input  logic [7:0]        rd_lo_idx,
  input  logic [7:0]        rd_hi_idx,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi
);

  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [HALF_W-1:0] mem [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= '1;
      else if (wr_en && wr_row == IDX_W'(g))       mem[g] <= wr_data;
    end
  end

  assign cmp_data = (cmp_row < IDX_W'(ROWS)) ? mem[cmp_row[ROW_W-1:0]] : '1;
  assign rd_lo    = (rd_lo_idx < 8'(ROWS))   ? mem[rd_lo_idx[ROW_W-1:0]] : '1;
  assign rd_hi    = (rd_hi_idx < 8'(ROWS))   ? mem[rd_hi_idx[ROW_W-1:0]] : '1;

endmodule

// File: rtl/kpd_seq.sv
module kpd_seq
  import kpd_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kpd_mode_e         mode,
  input  logic [13:0]       row_delay,
  input  logic [15:0]       scan_gap,
  input  logic [7:0]        eff_rows,
  input  logic [7:0]        ncols,
  input  logic [HALF_W-1:0] col_pad,
  input  logic [HALF_W-1:0] cur_data,
  output logic [ROWS-1:0]   row_drive_n,
  output logic [IDX_W-1:0]  row_idx,
  output logic              wr_en,
  output logic [HALF_W-1:0] wr_data,
  output logic              scan_done,
  output logic              scan_chg,
  output logic              key_any
);

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_GAP} seq_state_e;

  seq_state_e  state;
  logic [15:0] cnt;
  logic        chg;

  logic       scanning;
  logic [7:0] row_ext;
  logic       row_live;
  logic       last_row;
  logic       sample_now;
  logic       row_diff;

  assign scanning   = (mode == MODE_ONCE) || (mode == MODE_LOOP);
  assign row_ext    = 8'(row_idx);
  assign row_live   = row_ext < eff_rows;
  assign last_row   = (row_ext + 8'd1) >= eff_rows;
  assign sample_now = scanning && state == S_ROW && cnt == {2'b00, row_delay};

  assign wr_data   = fill_cols(col_pad, ncols);
  assign wr_en     = sample_now && row_live;
  assign row_diff  = wr_en && (wr_data != cur_data);
  assign scan_done = sample_now && last_row;
  assign scan_chg  = scan_done && (chg || row_diff);
  assign key_any   = (mode == MODE_ANYKEY) && !(&col_pad);

  always_comb begin
    row_drive_n = '1;
    if (mode == MODE_ANYKEY)
      row_drive_n = '0;
    else if (scanning && state == S_ROW && row_live)
      row_drive_n = ~(ROWS'(1) << row_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      row_idx <= '0;
      chg     <= 1'b0;
    end else if (!scanning) begin
      state   <= S_IDLE;
      cnt     <= '0;
      row_idx <= '0;
      chg     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          state   <= S_ROW;
          cnt     <= '0;
          row_idx <= '0;
          chg     <= 1'b0;
        end
        S_ROW: begin
          if (sample_now) begin
            cnt <= '0;
            chg <= chg | row_diff;
            if (last_row) state <= (mode == MODE_LOOP) ? S_GAP : S_IDLE;
            else          row_idx <= row_idx + IDX_W'(1);
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        S_GAP: begin
          if (cnt == scan_gap) begin
            state   <= S_ROW;
            cnt     <= '0;
            row_idx <= '0;
            chg     <= 1'b0;
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [ROWS-1:0]   row_drive_n,
  input  logic [COLS-1:0]   col_in_n,
  output logic              irq
);

  localparam int         IDX_W      = $clog2(ROWS + 1);
  localparam int         WORD_W     = ADDR_W - 2;
  localparam int         DATA_WORDS = (ROWS + 1) / 2;
  localparam logic [7:0] ROWS_L     = 8'(ROWS);
  localparam logic [WORD_W-1:0] W_DATA0 = WORD_W'(4);

  logic [31:0]       ctrl_q;
  logic [15:0]       size_q;
  logic [2:0]        status_q;
  logic [2:0]        mask_q;
  logic [1:0]        mode_bits;
  kpd_mode_e         mode;
  logic [7:0]        eff_rows;
  logic [7:0]        ncols;
  logic [HALF_W-1:0] col_pad;
  logic [IDX_W-1:0]  row_idx;
  logic [HALF_W-1:0] cur_data;
  logic              wr_en;
  logic [HALF_W-1:0] wr_data;
  logic              scan_done;
  logic              scan_chg;
  logic              key_any;
  logic              clr_mode;
  logic              aligned;
  logic              reg_wr;
  logic [WORD_W-1:0] word;
  logic [7:0]        pair;
  logic [7:0]        rd_lo_idx;
  logic [7:0]        rd_hi_idx;
  logic [HALF_W-1:0] rd_lo;
  logic [HALF_W-1:0] rd_hi;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign reg_wr    = bus_wr && aligned;
  assign word      = bus_addr[ADDR_W-1:2];
  assign mode_bits = ctrl_q[1:0];
  assign mode      = kpd_mode_e'(mode_bits);
  assign eff_rows  = clamp_count(size_q[7:0], ROWS_L);
  assign ncols     = size_q[15:8];
  assign clr_mode  = scan_done && (mode == MODE_ONCE);

  if (COLS >= int'(HALF_W)) begin : g_col_wide
    assign col_pad = col_in_n[HALF_W-1:0];
  end else begin : g_col_narrow
    assign col_pad = {{(int'(HALF_W) - COLS){1'b1}}, col_in_n};
  end

  kpd_regs #(.WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .word     (word),
    .wdata    (bus_wdata),
    .evt_done (scan_done),
    .evt_chg  (scan_chg),
    .evt_key  (key_any),
    .clr_mode (clr_mode),
    .ctrl_q   (ctrl_q),
    .size_q   (size_q),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  kpd_seq #(.ROWS(ROWS), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .row_delay   (ctrl_q[15:2]),
    .scan_gap    (ctrl_q[31:16]),
    .eff_rows    (eff_rows),
    .ncols       (ncols),
    .col_pad     (col_pad),
    .cur_data    (cur_data),
    .row_drive_n (row_drive_n),
    .row_idx     (row_idx),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .scan_done   (scan_done),
    .scan_chg    (scan_chg),
    .key_any     (key_any)
  );

  assign pair      = 8'(word) - 8'd4;
  assign rd_lo_idx = {pair[6:0], 1'b0};
  assign rd_hi_idx = {pair[6:0], 1'b1};

  kpd_rowstore #(.ROWS(ROWS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_row    (row_idx),
    .wr_data   (wr_data),
    .cmp_row   (row_idx),
    .cmp_data  (cur_data),
    .rd_lo_idx (rd_lo_idx),
    .rd_hi_idx (rd_hi_idx),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        WORD_W'(0): bus_rdata = ctrl_q;
        WORD_W'(1): bus_rdata = {16'h0000, size_q};
        WORD_W'(2): bus_rdata = {29'd0, status_q};
        WORD_W'(3): bus_rdata = {29'd0, mask_q};
        default: begin
          if (word >= W_DATA0 && word < W_DATA0 + WORD_W'(DATA_WORDS))
            bus_rdata = {rd_hi, rd_lo};
        end
      endcase
    end
  end

endmodule

// File: rtl/kpd_scan_chk.sv
module kpd_scan_chk #(
  parameter int ROWS  = 16,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       mode_bits,
  input logic [ROWS-1:0]  row_drive_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] row_idx,
  input logic [7:0]       eff_rows,
  input logic [7:0]       ncols,
  input logic [15:0]      wr_data,
  input logic             scan_done,
  input logic             key_any,
  input logic [2:0]       status_q
);

  a_r3_single_row_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'd2 || mode_bits == 2'd3) |-> $onehot0(~row_drive_n));

  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'd0) |-> (&row_drive_n));

  a_r4_once_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode_bits == 2'd2 && !bus_wr) |=> (mode_bits == 2'd0));

  a_r5_no_stale_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (8'(row_idx) < eff_rows));

  a_r6_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ncols < 8'd16) |-> wr_data[15]);

  a_r8_key_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    key_any |=> status_q[2]);

  a_r8_frozen_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'd1) |-> !wr_en);

endmodule

bind kpd_scan_top kpd_scan_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .mode_bits   (mode_bits),
  .row_drive_n (row_drive_n),
  .wr_en       (wr_en),
  .row_idx     (row_idx),
  .eff_rows    (eff_rows),
  .ncols       (ncols),
  .wr_data     (wr_data),
  .scan_done   (scan_done),
  .key_any     (key_any),
  .status_q    (status_q)
);

// File: tb/test_kpd_scan_top.sv
module test_kpd_scan_top;

  localparam int CLK_PERIOD = 10;

  // {row count, column count, key row, key column}
  localparam logic [31:0] VEC [8] = '{
    32'h0408_0103, 32'h0408_0103, 32'h0208_0300, 32'h1010_050F,
    32'h0310_0002, 32'h1004_0209, 32'h2810_0F00, 32'h0010_0000
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] row_drive_n;
  logic [15:0] col_in_n;
  logic        irq;
  logic [255:0] keys = '0;
  logic [15:0] exp_rows [16];
  int tests = 0;
  int fails = 0;

  kpd_scan_top i_kpd_scan_top (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .row_drive_n, .col_in_n, .irq
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // keypad matrix: a pressed key pulls its column low while its row is driven
  always_comb begin
    col_in_n = '1;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        if (!row_drive_n[r] && keys[r * 16 + c]) col_in_n[c] = 1'b0;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(8'h08, v);
      if (v[0]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_rows(input string req);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(8'h10 + 8'(4 * k), v);
      chk(req, $sformatf("data word %0d", k), v, {exp_rows[2*k+1], exp_rows[2*k]});
    end
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL R4 watchdog expired: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    bit ok;
    for (int r = 0; r < 16; r++) exp_rows[r] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1", "control", v, 32'h0);
    rd(8'h04, v); chk("R1", "size", v, 32'h0);
    rd(8'h08, v); chk("R1", "status", v, 32'h0);
    rd(8'h0C, v); chk("R1", "mask", v, 32'h0);
    chk("R1", "rows", 32'(row_drive_n), 32'h0000_FFFF);
    chk("R1", "irq", 32'(irq), 32'h0);
    check_rows("R1");
    // R2 unmapped and misaligned addresses
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R2", "unmapped read", v, 32'h0);
    wr(8'h05, 32'h0000_1234);
    rd(8'h04, v); chk("R2", "misaligned write ignored", v, 32'h0);
    rd(8'h01, v); chk("R2", "misaligned read", v, 32'h0);

    // table of single scans: R4 R5 R6 R7
    foreach (VEC[i]) begin
      logic [7:0] nr, nc, kr, kc;
      int eff;
      logic chg;
      {nr, nc, kr, kc} = VEC[i];
      keys = '0;
      keys[kr * 16 + kc] = 1'b1;
      eff = (nr > 8'd16) ? 16 : int'(nr);
      chg = 1'b0;
      for (int r = 0; r < eff; r++) begin
        logic [15:0] e;
        e = 16'hFFFF;
        if (r == int'(kr) && kc < nc) e[kc] = 1'b0;
        if (e != exp_rows[r]) chg = 1'b1;
        exp_rows[r] = e;
      end
      wr(8'h08, 32'h7);
      wr(8'h04, {16'h0, nc, nr});
      wr(8'h00, 32'h0000_000A);
      wait_done(ok);
      chk("R4", $sformatf("vector %0d done", i), 32'(ok), 32'h1);
      rd(8'h00, v); chk("R4", "mode back to idle", 32'(v[1:0]), 32'h0);
      check_rows("R5 R6");
      rd(8'h08, v); chk("R7", $sformatf("vector %0d changed flag", i), 32'(v[1]), 32'(chg));
    end

    // R8 any-key detect
    keys = '0;
    wr(8'h08, 32'h7);
    wr(8'h04, 32'h0000_1010);
    wr(8'h00, 32'h0000_0001);
    repeat (2) @(negedge clk);
    rd(8'h08, v); chk("R8", "no key no flag", 32'(v[2]), 32'h0);
    chk("R3", "any-key drives all rows", 32'(row_drive_n), 32'h0);
    keys[2 * 16 + 4] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h08, v); chk("R8", "key flag set", 32'(v[2]), 32'h1);
    wr(8'h08, 32'h4);
    rd(8'h08, v); chk("R8", "flag held while pressed", 32'(v[2]), 32'h1);
    check_rows("R8");
    keys = '0;
    repeat (2) @(negedge clk);
    wr(8'h08, 32'h4);
    rd(8'h08, v); chk("R8", "flag cleared after release", 32'(v[2]), 32'h0);
    wr(8'h00, 32'h0);
    chk("R3", "idle releases rows", 32'(row_drive_n), 32'h0000_FFFF);

    // R3 single row during scan
    wr(8'h04, 32'h0000_1004);
    wr(8'h00, 32'h0000_0052);
    repeat (3) @(negedge clk);
    chk("R3", "one row low", 32'($countones(~row_drive_n)), 32'h1);
    chk("R3", "row 0 first", 32'(row_drive_n), 32'h0000_FFFE);

    // R11 abort mid scan
    wr(8'h00, 32'h0);
    chk("R11", "rows released on abort", 32'(row_drive_n), 32'h0000_FFFF);
    wr(8'h08, 32'h7);
    wr(8'h04, 32'h0000_1010);
    wr(8'h00, 32'h0000_00CA);
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h0);
    chk("R11", "rows released", 32'(row_drive_n), 32'h0000_FFFF);
    repeat (900) @(negedge clk);
    rd(8'h08, v); chk("R11", "no done after abort", 32'(v[0]), 32'h0);

    // R10 interrupt masking
    wr(8'h0C, 32'h1);
    wr(8'h04, 32'h0000_1001);
    wr(8'h00, 32'h0000_0002);
    wait_done(ok);
    chk("R10", "irq with mask", 32'(irq), 32'h1);
    wr(8'h0C, 32'h0);
    chk("R10", "irq masked off", 32'(irq), 32'h0);
    wr(8'h0C, 32'h1);
    chk("R10", "irq unmasked", 32'(irq), 32'h1);
    wr(8'h08, 32'h1);
    chk("R10", "irq after clear", 32'(irq), 32'h0);

    // R9 continuous scan period: 2 rows, settle 3, gap 5 -> 14
    begin
      int first;
      int period;
      logic prev;
      first = -1; period = -1; prev = 1'b1;
      wr(8'h04, 32'h0000_1002);
      wr(8'h00, 32'h0005_000F);
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (prev && !row_drive_n[0]) begin
          if (first < 0) first = i;
          else begin period = i - first; break; end
        end
        prev = row_drive_n[0];
      end
      chk("R9", "row 0 period", 32'(period), 32'd14);
      rd(8'h00, v); chk("R9", "mode stays continuous", 32'(v[1:0]), 32'h3);
      wr(8'h00, 32'h0);
    end

    finish_up();
  end

endmodule